// File: doc/BRIEF.md
# DMA Channel Search-Match and Termination Unit

This unit decides when one DMA channel operation ends and what happens next. A start pulse captures the channel setup: the operation kind, the match control, the pattern and don't-care mask, the completion options, the operation count and the two current addresses with their step modes. The values captured at start also become the base copies. While the operation runs, each data word read from the source arrives on a valid/ready stream. Every accepted word steps the addresses and decrements the operation count. In the two search kinds, the word is also compared against the pattern.

An operation ends for one or more of three reasons. Terminal count means the operation count has reached zero. End-of-process means the external input was asserted. Match means the compare condition was met. The unit records every reason that fires in the ending cycle and holds them until the next start. It then ORs together the follow-up actions selected for those reasons: an interrupt pulse, a base-to-current reload, or a chain-reload request. A base-to-current reload restores the count and both addresses from their base copies inside the block, with no memory access.

Stream rules: `s_ready` is high exactly while an operation is running. A word counts as accepted on a clock edge where `s_valid` and `s_ready` are both high. The source may hold or drop `s_valid` at any time. No word is accepted while the unit is idle, and `s_data` is ignored when no word is accepted.

Top module: `dma_term_unit`

## Requirements
- R1: After reset the unit is idle, with `busy_o`=0, `cause_o`=0 and `count_o`=0. When `start` arrives while idle, the edge loads the count and both addresses (current and base) from the configuration ports, sets `busy_o` and clears `cause_o`. A `start` that arrives while busy changes nothing.
- R2: `s_ready` equals `busy_o`. Each accepted word lowers `count_o` by one.
- R3: When an accepted word takes the count from 1 to 0, the operation ends with cause bit 0 (terminal count). A programmed count of 0 means 65536 words. `term_o` is high for the one cycle after the ending edge.
- R4: For compare, a mask bit of 1 makes that bit position always match. Match code 2 (`cfg_match`=2'b10) ends the operation on the accepted word whose masked 16-bit value equals the pattern, setting cause bit 2.
- R5: Match code 3 compares only bits 7:0 of the data and the pattern under the mask. The upper byte is ignored.
- R6: Match code 1 ends the operation on the first accepted word whose masked value differs from the pattern. Match code 0 never ends the operation.
- R7: Kind codes are 0 = transfer, 1 = search, 2 = transfer-and-search, and 3 behaves as transfer. A transfer never ends on a match. A search steps only the source address. The other kinds step both addresses.
- R8: Step codes are 0 = hold, 1 = +1, 2 = −1, and 3 = hold. Addresses wrap within 22 bits. `cfg_flip`=0 makes address A the source, and `cfg_flip`=1 makes address B the source.
- R9: `eop_in` high in any busy cycle ends the operation at that edge, with or without an accepted word, setting cause bit 1.
- R10: `cause_o` holds every cause that fired on the ending edge: bit 0 terminal count, bit 1 end-of-process, bit 2 match. It keeps that value until the next accepted start.
- R11: `cfg_opts` holds three 3-bit groups: bits 2:0 for terminal count, 5:3 for end-of-process and 8:6 for match. Within each group, bit 0 is interrupt, bit 1 is reload and bit 2 is chain. Each of `irq_o`, `reload_o` and `chain_o` pulses for one cycle, together with `term_o`, when any fired cause selects that action.
- R12: When reload is selected, the ending edge restores the count and both addresses from the base copies taken at start, instead of leaving the stepped values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; acted on only while idle |
| cfg_kind | input | 2 | Operation kind code |
| cfg_match | input | 2 | Match control code |
| cfg_flip | input | 1 | Selects which address is the source |
| cfg_pattern | input | 16 | Compare pattern |
| cfg_mask | input | 16 | Don't-care mask, 1 = always match |
| cfg_opts | input | 9 | Completion actions for each cause |
| cfg_count | input | 16 | Operation count, 0 = 65536 |
| cfg_addr_a | input | 22 | Start address A |
| cfg_addr_b | input | 22 | Start address B |
| cfg_step_a | input | 2 | Step mode for address A |
| cfg_step_b | input | 2 | Step mode for address B |
| eop_in | input | 1 | External end-of-process |
| s_valid | input | 1 | Source word valid |
| s_ready | output | 1 | Unit accepts words |
| s_data | input | 16 | Source word |
| busy_o | output | 1 | Operation running |
| term_o | output | 1 | One-cycle pulse after an operation ends |
| cause_o | output | 3 | Recorded termination causes |
| irq_o | output | 1 | Interrupt pulse |
| reload_o | output | 1 | Base-to-current reload pulse |
| chain_o | output | 1 | Chain-reload request pulse |
| count_o | output | 16 | Current operation count |
| addr_a_o | output | 22 | Current address A |
| addr_b_o | output | 22 | Current address B |

## Verification
The hardest state to reach is a single ending edge on which all three causes fire together. This needs a count of one, a word that meets the match condition, and end-of-process raised in the same cycle, with a different action selected for each cause. The bench builds that cycle on purpose and checks that all three pulses appear and that the reload undoes the address step. The other hard state is the last word of a count programmed as zero. The stimulus holds `s_valid` high for 65536 edges so the 0→65535 wrap and the final terminal count are both observed.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [1:0] {
    KIND_XFER  = 2'd0,
    KIND_SRCH  = 2'd1,
    KIND_XSRCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    MC_OFF      = 2'd0,
    MC_WORD_MIS = 2'd1,
    MC_WORD_HIT = 2'd2,
    MC_BYTE_HIT = 2'd3
  } mctl_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_INC   = 2'd1,
    STEP_DEC   = 2'd2,
    STEP_HOLD3 = 2'd3
  } step_e;

  localparam int NCAUSE    = 3;
  localparam int CAUSE_TC  = 0;
  localparam int CAUSE_EOP = 1;
  localparam int CAUSE_MC  = 2;
  localparam int ACT_W     = 3;

  typedef struct packed {
    logic chain;
    logic reload;
    logic irq;
  } act_t;
endpackage

// File: rtl/dma_match_cmp.sv
module dma_match_cmp
  import dma_term_pkg::*;
#(
  parameter int DW = 16,
  parameter int LANE = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] pattern,
  input  logic [DW-1:0] mask,
  input  mctl_e         mctl,
  output logic          hit
);
  logic [DW-1:0] diff;
  assign diff = (data ^ pattern) & ~mask;

  always_comb begin
    case (mctl)
      MC_WORD_MIS: hit = |diff;
      MC_WORD_HIT: hit = ~|diff;
      MC_BYTE_HIT: hit = ~|diff[LANE-1:0];
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_count_ctr.sv
module dma_count_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic          reload,
  output logic [CW-1:0] q,
  output logic          last
);
  logic [CW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      base_q <= '0;
    end else if (load) begin
      q      <= load_val;
      base_q <= load_val;
    end else if (reload) begin
      q <= base_q;
    end else if (dec) begin
      q <= q - CW'(1);
    end
  end

  assign last = (q == CW'(1));

  // R2: a plain decrement moves the count down by exactly one
  p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !reload) |=> (q == $past(q) - CW'(1)));
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_term_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  step_e         load_mode,
  input  logic          step_en,
  input  logic          reload,
  output logic [AW-1:0] q
);
  logic [AW-1:0] base_q;
  step_e         mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      base_q <= '0;
      mode_q <= STEP_HOLD;
    end else if (load) begin
      q      <= load_val;
      base_q <= load_val;
      mode_q <= load_mode;
    end else if (reload) begin
      q <= base_q;
    end else if (step_en) begin
      case (mode_q)
        STEP_INC: q <= q + AW'(1);
        STEP_DEC: q <= q - AW'(1);
        default:  q <= q;
      endcase
    end
  end

  // R8: hold modes keep the address while words flow
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && !reload && (mode_q == STEP_HOLD || mode_q == STEP_HOLD3))
      |=> $stable(q));

  // R8: increment mode advances by one
  p_step_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && !reload && mode_q == STEP_INC) |=> (q == $past(q) + AW'(1)));
endmodule

// File: rtl/dma_term_unit.sv
module dma_term_unit
  import dma_term_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 22,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_kind,
  input  logic [1:0]       cfg_match,
  input  logic             cfg_flip,
  input  logic [DW-1:0]    cfg_pattern,
  input  logic [DW-1:0]    cfg_mask,
  input  logic [8:0]       cfg_opts,
  input  logic [CW-1:0]    cfg_count,
  input  logic [AW-1:0]    cfg_addr_a,
  input  logic [AW-1:0]    cfg_addr_b,
  input  logic [1:0]       cfg_step_a,
  input  logic [1:0]       cfg_step_b,
  input  logic             eop_in,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  output logic             busy_o,
  output logic             term_o,
  output logic [2:0]       cause_o,
  output logic             irq_o,
  output logic             reload_o,
  output logic             chain_o,
  output logic [CW-1:0]    count_o,
  output logic [AW-1:0]    addr_a_o,
  output logic [AW-1:0]    addr_b_o
);
  localparam int OPT_W = NCAUSE * ACT_W;
  localparam int NADDR = 2;

  // latched setup
  kind_e            kind_q;
  mctl_e            mctl_q;
  logic             flip_q;
  logic [DW-1:0]    pat_q;
  logic [DW-1:0]    mask_q;
  logic [OPT_W-1:0] opts_q;

  logic             busy_q;
  logic             start_ok;
  logic             beat;
  logic             hit;
  logic             srch_kind;
  logic             cnt_last;
  logic [NCAUSE-1:0] causes;
  logic             fin;
  act_t             act_vec [NCAUSE];
  act_t             act_any;
  logic             do_reload;

  assign start_ok  = start && !busy_q;
  assign beat      = s_valid && busy_q;
  assign s_ready   = busy_q;
  assign busy_o    = busy_q;
  assign srch_kind = (kind_q == KIND_SRCH) || (kind_q == KIND_XSRCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= KIND_XFER;
      mctl_q <= MC_OFF;
      flip_q <= 1'b0;
      pat_q  <= '0;
      mask_q <= '0;
      opts_q <= '0;
    end else if (start_ok) begin
      kind_q <= kind_e'(cfg_kind);
      mctl_q <= mctl_e'(cfg_match);
      flip_q <= cfg_flip;
      pat_q  <= cfg_pattern;
      mask_q <= cfg_mask;
      opts_q <= cfg_opts;
    end
  end

  dma_match_cmp #(.DW(DW), .LANE(8)) u_cmp (
    .data    (s_data),
    .pattern (pat_q),
    .mask    (mask_q),
    .mctl    (mctl_q),
    .hit     (hit)
  );

  assign causes[CAUSE_TC]  = beat && cnt_last;
  assign causes[CAUSE_EOP] = busy_q && eop_in;
  assign causes[CAUSE_MC]  = beat && srch_kind && hit;
  assign fin = |causes;

  for (genvar c = 0; c < NCAUSE; c++) begin : g_act
    assign act_vec[c] = causes[c] ? act_t'(opts_q[c*ACT_W +: ACT_W]) : act_t'('0);
  end

  always_comb begin
    act_any = '0;
    for (int c = 0; c < NCAUSE; c++) begin
      act_any = act_any | act_vec[c];
    end
  end

  assign do_reload = fin && act_any.reload;

  dma_count_ctr #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (cfg_count),
    .dec      (beat),
    .reload   (do_reload),
    .q        (count_o),
    .last     (cnt_last)
  );

  // address A is index 0, address B is index 1
  logic [AW-1:0] a_load [NADDR];
  step_e         a_mode [NADDR];
  logic          a_step [NADDR];
  logic [AW-1:0] a_q    [NADDR];

  assign a_load[0] = cfg_addr_a;
  assign a_load[1] = cfg_addr_b;
  assign a_mode[0] = step_e'(cfg_step_a);
  assign a_mode[1] = step_e'(cfg_step_b);

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    // in a search only the source side moves; flip picks the source
    logic is_src;
    assign is_src    = (flip_q == (g == 1));
    assign a_step[g] = beat && ((kind_q != KIND_SRCH) || is_src);

    dma_addr_ctr #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_ok),
      .load_val  (a_load[g]),
      .load_mode (a_mode[g]),
      .step_en   (a_step[g]),
      .reload    (do_reload),
      .q         (a_q[g])
    );
  end

  assign addr_a_o = a_q[0];
  assign addr_b_o = a_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cause_o  <= '0;
      term_o   <= 1'b0;
      irq_o    <= 1'b0;
      reload_o <= 1'b0;
      chain_o  <= 1'b0;
    end else begin
      term_o   <= fin;
      irq_o    <= fin && act_any.irq;
      reload_o <= do_reload;
      chain_o  <= fin && act_any.chain;
      if (start_ok) begin
        busy_q  <= 1'b1;
        cause_o <= '0;
      end else if (fin) begin
        busy_q  <= 1'b0;
        cause_o <= causes;
      end
    end
  end

  // R1: an accepted start leaves the unit running with no cause recorded
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy_o && cause_o == 3'b000));

  // R9: end-of-process while running always stops the operation
  p_eop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && eop_in) |=> (!busy_o && cause_o[CAUSE_EOP]));

  // R10: a termination pulse always comes with a recorded cause and an idle unit
  p_term_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> (!busy_o && cause_o != 3'b000));

  // R11: action pulses only accompany a termination
  p_act_with_term_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || reload_o || chain_o) |-> term_o);

  // R4: a fully masked word compare matches any accepted word in a search kind
  p_full_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && srch_kind && mctl_q == MC_WORD_HIT && mask_q == '1) |=> cause_o[CAUSE_MC]);

  // R3: the last count word ends the operation as terminal count
  p_tc_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && count_o == CW'(1)) |=> (term_o && cause_o[CAUSE_TC]));
endmodule

// File: tb/sim_dma_term_unit.sv
`timescale 1ns/1ps
module sim_dma_term_unit;
  localparam int AMASK = 22'h3FFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0;
  logic [1:0] cfg_kind = 0, cfg_match = 0, cfg_step_a = 0, cfg_step_b = 0;
  logic cfg_flip = 0;
  logic [15:0] cfg_pattern = 0, cfg_mask = 0, cfg_count = 0;
  logic [8:0] cfg_opts = 0;
  logic [21:0] cfg_addr_a = 0, cfg_addr_b = 0;
  logic eop_in = 0, s_valid = 0;
  logic [15:0] s_data = 0;
  logic s_ready, busy_o, term_o, irq_o, reload_o, chain_o;
  logic [2:0] cause_o;
  logic [15:0] count_o;
  logic [21:0] addr_a_o, addr_b_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_term_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_kind(cfg_kind), .cfg_match(cfg_match),
    .cfg_flip(cfg_flip), .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask), .cfg_opts(cfg_opts),
    .cfg_count(cfg_count), .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b),
    .cfg_step_a(cfg_step_a), .cfg_step_b(cfg_step_b), .eop_in(eop_in), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .busy_o(busy_o), .term_o(term_o), .cause_o(cause_o),
    .irq_o(irq_o), .reload_o(reload_o), .chain_o(chain_o), .count_o(count_o),
    .addr_a_o(addr_a_o), .addr_b_o(addr_b_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_busy, m_cause, m_term, m_irq, m_rel, m_chn;
  int  m_cnt, m_bcnt, m_a, m_b, m_ba, m_bb;
  int  m_kind, m_mc, m_flip, m_pat, m_mask, m_opts, m_sa, m_sb;

  function automatic int stepv(input int v, input int mode);
    if (mode == 1) return (v + 1) & AMASK;
    if (mode == 2) return (v - 1) & AMASK;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cause = 0; m_term = 0; m_irq = 0; m_rel = 0; m_chn = 0;
      m_cnt = 0; m_bcnt = 0; m_a = 0; m_b = 0; m_ba = 0; m_bb = 0;
      m_kind = 0; m_mc = 0; m_flip = 0; m_pat = 0; m_mask = 0; m_opts = 0; m_sa = 0; m_sb = 0;
    end else begin
      int tc, ep, mt, beat, d, cs, acts;
      m_term = 0; m_irq = 0; m_rel = 0; m_chn = 0;
      beat = (s_valid && m_busy) ? 1 : 0;
      if (start && !m_busy) begin
        m_kind = cfg_kind; m_mc = cfg_match; m_flip = cfg_flip; m_pat = cfg_pattern;
        m_mask = cfg_mask; m_opts = cfg_opts; m_sa = cfg_step_a; m_sb = cfg_step_b;
        m_cnt = (cfg_count == 0) ? 65536 : cfg_count; m_bcnt = m_cnt;
        m_a = cfg_addr_a; m_b = cfg_addr_b; m_ba = m_a; m_bb = m_b;
        m_busy = 1; m_cause = 0;
      end else if (m_busy) begin
        d  = (s_data ^ m_pat) & ~m_mask & 16'hFFFF;
        mt = 0;
        if (beat && (m_kind == 1 || m_kind == 2)) begin
          if (m_mc == 1) mt = (d != 0);
          if (m_mc == 2) mt = (d == 0);
          if (m_mc == 3) mt = ((d & 8'hFF) == 0);
        end
        tc = beat && (m_cnt == 1);
        ep = eop_in ? 1 : 0;
        if (beat) begin
          m_cnt = m_cnt - 1;
          if (m_kind != 1 || m_flip == 0) m_a = stepv(m_a, m_sa);
          if (m_kind != 1 || m_flip == 1) m_b = stepv(m_b, m_sb);
        end
        cs = tc | (ep << 1) | (mt << 2);
        if (cs != 0) begin
          acts = 0;
          for (int c = 0; c < 3; c++) if ((cs >> c) & 1) acts |= (m_opts >> (3 * c)) & 7;
          m_busy = 0; m_cause = cs; m_term = 1;
          m_irq = acts & 1; m_rel = (acts >> 1) & 1; m_chn = (acts >> 2) & 1;
          if (m_rel) begin m_cnt = m_bcnt; m_a = m_ba; m_b = m_bb; end
        end
      end
      #1;
      chk("R1 busy",  busy_o,   m_busy);
      chk("R2 ready", s_ready,  m_busy);
      chk("R2 count", count_o,  m_cnt & 16'hFFFF);
      chk("R8 addrA", addr_a_o, m_a);
      chk("R8 addrB", addr_b_o, m_b);
      chk("R10 cause", cause_o, m_cause);
      chk("R3 term",  term_o,   m_term);
      chk("R11 irq",  irq_o,    m_irq);
      chk("R12 rel",  reload_o, m_rel);
      chk("R11 chain", chain_o, m_chn);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go(input int kind, input int mc, input int flip, input int pat, input int msk,
                    input int opts, input int cnt, input int a, input int b, input int sa, input int sb);
    cfg_kind = 2'(kind); cfg_match = 2'(mc); cfg_flip = flip[0]; cfg_pattern = 16'(pat);
    cfg_mask = 16'(msk); cfg_opts = 9'(opts); cfg_count = 16'(cnt); cfg_addr_a = 22'(a);
    cfg_addr_b = 22'(b); cfg_step_a = 2'(sa); cfg_step_b = 2'(sb);
    start = 1; tick(); start = 0;
  endtask

  task automatic word(input int d);
    s_valid = 1; s_data = 16'(d); tick(); s_valid = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset cause", cause_o, 0);
    chk("R1 reset count", count_o, 0);

    // transfer, TC with irq; matching data must not end a transfer (R7)
    go(0, 2, 0, 16'h1234, 0, 9'o001, 3, 22'h10, 22'h200, 1, 2);
    chk("R1 start busy", busy_o, 1);
    chk("R1 start count", count_o, 3);
    word(16'h1234); word(16'h1234);
    chk("R7 xfer no match", busy_o, 1);
    chk("R2 count dec", count_o, 1);
    word(16'h1234);
    chk("R3 tc cause", cause_o, 1);
    chk("R3 term pulse", term_o, 1);
    chk("R11 irq pulse", irq_o, 1);
    chk("R8 inc A", addr_a_o, 22'h13);
    chk("R8 dec B", addr_b_o, 22'h1FD);
    tick();
    chk("R11 irq one cycle", irq_o, 0);
    chk("R10 cause held", cause_o, 1);

    // search with mask, match -> chain; only source A steps
    go(1, 2, 0, 16'h1234, 16'h00F0, 9'o400, 10, 22'h40, 22'h80, 1, 1);
    word(16'h1111);
    chk("R4 miss keeps running", busy_o, 1);
    word(16'h12F4);
    chk("R4 masked match", cause_o, 4);
    chk("R11 chain pulse", chain_o, 1);
    chk("R7 search src steps", addr_a_o, 22'h42);
    chk("R7 search dst holds", addr_b_o, 22'h80);
    chk("R2 count after two", count_o, 8);
    tick();

    // search with flip: only B steps (R8)
    go(1, 0, 1, 0, 0, 0, 2, 22'h5, 22'h9, 1, 1);
    word(0); word(0);
    chk("R8 flip A holds", addr_a_o, 22'h5);
    chk("R8 flip B steps", addr_b_o, 22'hB);
    tick();

    // byte match in transfer-and-search
    go(2, 3, 0, 16'hAB55, 0, 0, 20, 22'h100, 22'h3FFFFF, 2, 1);
    word(16'h5500);
    chk("R5 low byte differs", busy_o, 1);
    word(16'hFF55);
    chk("R5 byte match", cause_o, 4);
    chk("R8 B wraps", addr_b_o, 22'h1);
    tick();

    // stop on mismatch
    go(2, 1, 0, 16'h00AA, 0, 0, 20, 0, 0, 0, 0);
    word(16'h00AA); word(16'h00AA);
    chk("R6 equal continues", busy_o, 1);
    word(16'h00AB);
    chk("R6 mismatch ends", cause_o, 4);
    tick();
    go(2, 0, 0, 16'h00AA, 0, 0, 3, 0, 0, 0, 0);
    word(16'h1);
    chk("R6 code0 no match end", busy_o, 1);
    eop_in = 1; tick(); eop_in = 0;

    // EOP without a word
    go(0, 0, 0, 0, 0, 9'o010, 5, 0, 0, 1, 1);
    tick();
    eop_in = 1; tick(); eop_in = 0;
    chk("R9 eop cause", cause_o, 2);
    chk("R9 count untouched", count_o, 5);
    chk("R11 eop irq", irq_o, 1);
    tick();

    // start while busy ignored
    go(0, 0, 0, 0, 0, 0, 4, 0, 0, 0, 0);
    go(0, 0, 0, 0, 0, 0, 9, 0, 0, 0, 0);
    chk("R1 restart ignored", count_o, 4);
    eop_in = 1; tick(); eop_in = 0;

    // all three causes together, each with its own action
    go(1, 2, 0, 16'hBEEF, 0, 9'o421, 1, 22'h700, 22'h800, 1, 1);
    eop_in = 1; word(16'hBEEF); eop_in = 0;
    chk("R10 all causes", cause_o, 7);
    chk("R11 irq", irq_o, 1);
    chk("R11 reload", reload_o, 1);
    chk("R11 chain", chain_o, 1);
    chk("R12 addr restored", addr_a_o, 22'h700);
    chk("R12 count restored", count_o, 1);
    tick();

    // TC reload only
    go(2, 0, 0, 0, 0, 9'o002, 2, 22'h20, 22'h30, 1, 2);
    word(1); word(2);
    chk("R12 reload count", count_o, 2);
    chk("R12 reload A", addr_a_o, 22'h20);
    chk("R12 reload B", addr_b_o, 22'h30);
    chk("R12 no irq", irq_o, 0);
    tick();

    // zero count = 65536 words
    go(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    s_valid = 1;
    repeat (65535) tick();
    chk("R3 still busy at 65535", busy_o, 1);
    chk("R3 count one left", count_o, 1);
    tick();
    s_valid = 0;
    chk("R3 65536 ends tc", cause_o, 1);
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule